// File: doc/BRIEF.md
# Programmable Modulo-N Clock Divider

This block divides its input clock by a ratio N that is supplied at run time on a programming bus. It is meant for the feedback path of a frequency synthesiser. A wide up-counter is built from equal-width counter slices chained by carry. A slice-wise equality comparator checks the count against the terminal value N-1 and against the half-period value. A small controller turns those matches into a synchronous clear of the counter and a registered square-wave output. The controller also takes a new ratio only at the wrap of a period.

The controller has three named states. ST_ARM is entered on reset: the counter sits at zero and the bus is read live. ST_RUN is the state in which the block counts. ST_STALL is entered when a ratio below 2 is loaded at a wrap, and the block then stays idle at zero. The transitions are as follows. ARM→RUN and STALL→RUN fire on an enabled edge while the bus holds a usable ratio. RUN→STALL fires at an enabled wrap while the bus holds an unusable ratio. Otherwise each state holds.

When parameter `SMALL_HOLD` is 0, ratios 0 and 1 are treated as 2, so ST_STALL is never entered. The default is 1.

Top module: `moddiv_core`

## Requirements
- R1: A low level on `rst_ni` clears `count_o`, `div_o` and `term_o` to 0 at once, without waiting for a clock edge, and returns the controller to ST_ARM.
- R2: While `en_i` is low, no clock edge changes `count_o`, `div_o`, the ratio in use or the state.
- R3: In ST_RUN with ratio N, the count steps 0,1,…,N-1 on enabled edges and loads 0 on the enabled edge after N-1. `term_o` is high exactly while the count equals N-1, so it is high once per period.
- R4: In ST_RUN, `div_o` is a register output. It is high while the count is below ceil(N/2) and low for the remaining floor(N/2) counts, giving a period of N enabled cycles.
- R5: A new value on `ratio_i` during ST_RUN has no effect until the wrap that ends the current period. The period in progress still ends at the old N-1.
- R6: From ST_ARM or ST_STALL, the first enabled edge with `ratio_i` ≥ 2 loads that ratio and moves the count to 1. On that edge `div_o` becomes 1 if the ratio is 3 or more, and stays 0 for a ratio of 2.
- R7: With `SMALL_HOLD`=1, a ratio of 0 or 1 on the bus holds the block in ST_ARM or sends it to ST_STALL at the next wrap. In those states the count is 0 and both `div_o` and `term_o` are 0.
- R8: The counter is built from `CNT_W/STAGE_W` slices. A slice advances only when every lower slice is at its all-ones value, so every ratio from 2 to 2^CNT_W-1 counts correctly across slice boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Synchronous count enable, active high |
| ratio_i | input | CNT_W | Programmed division ratio N |
| count_o | output | CNT_W | Current count value |
| term_o | output | 1 | High while the count equals N-1 in ST_RUN |
| div_o | output | 1 | Divided clock, high for ceil(N/2) of N cycles |

## Verification
The hardest situation to reach from the ports is a ratio change that arrives in the middle of a period. It has to be shown both to stay invisible for the rest of that period and to take hold exactly at the wrap, including a change into the stalled state and back out of it. The bench runs a small 8-bit configuration built from two 4-bit slices. It sweeps every ratio from 2 to 255 in a row, so each new ratio is written while the previous one is still counting. This drives every slice-boundary carry and every wrap-time reload. Separate phases change the ratio a few counts into a period, gate the enable in an irregular pattern, load ratios 0 and 1, and pull reset between clock edges.

// File: rtl/moddiv_pkg.sv
package moddiv_pkg;

    typedef enum logic [1:0] {
        ST_ARM   = 2'd0,
        ST_RUN   = 2'd1,
        ST_STALL = 2'd2
    } div_state_e;

endpackage

// File: rtl/moddiv_stage.sv
module moddiv_stage #(
    parameter int unsigned W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] q_o,
    output logic         carry_o
);

    logic [W-1:0] q_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_q <= '0;
        end else if (clr_i) begin
            q_q <= '0;
        end else if (inc_i) begin
            q_q <= q_q + 1'b1;
        end
    end

    assign carry_o = inc_i & (&q_q);
    assign q_o     = q_q;

    // R8: a full slice that is told to advance rolls over to zero
    p_stage_rollover_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && !clr_i && (&q_q)) |=> (q_q == '0));

    // R8: without an advance or clear, the slice keeps its value
    p_stage_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!inc_i && !clr_i) |=> $stable(q_q));

endmodule

// File: rtl/moddiv_cmp.sv
module moddiv_cmp #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned STAGE_W = 4
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] ratio_i,
    output logic             hit_term_o,
    output logic             hit_half_o
);

    localparam int unsigned NSTG = CNT_W / STAGE_W;

    logic [CNT_W-1:0] term_val;
    logic [CNT_W-1:0] half_val;
    logic [NSTG-1:0]  eq_term;
    logic [NSTG-1:0]  eq_half;

    // terminal count is N-1; half point is ceil(N/2)-1
    assign term_val = ratio_i - 1'b1;
    assign half_val = (ratio_i >> 1) + {{(CNT_W-1){1'b0}}, ratio_i[0]} - 1'b1;

    for (genvar g = 0; g < NSTG; g++) begin : g_slice
        assign eq_term[g] = (count_i[g*STAGE_W +: STAGE_W] == term_val[g*STAGE_W +: STAGE_W]);
        assign eq_half[g] = (count_i[g*STAGE_W +: STAGE_W] == half_val[g*STAGE_W +: STAGE_W]);
    end

    assign hit_term_o = &eq_term;
    assign hit_half_o = &eq_half;

endmodule

// File: rtl/moddiv_ctrl.sv
module moddiv_ctrl
    import moddiv_pkg::*;
#(
    parameter int unsigned CNT_W      = 16,
    parameter bit          SMALL_HOLD = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [CNT_W-1:0] ratio_i,
    input  logic             hit_term_i,
    input  logic             hit_half_i,
    output logic             clr_o,
    output logic             inc_o,
    output logic [CNT_W-1:0] ratio_q_o,
    output logic             running_o,
    output logic             div_o
);

    div_state_e       state_q, state_d;
    logic [CNT_W-1:0] ratio_q;
    logic             div_q, div_d;
    logic             load;
    logic             small_in;
    logic             valid_in;
    logic [CNT_W-1:0] eff_in;

    assign small_in = (ratio_i < CNT_W'(2));
    assign valid_in = !small_in || !SMALL_HOLD;
    assign eff_in   = small_in ? CNT_W'(2) : ratio_i;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARM, ST_STALL: begin
                if (en_i && valid_in) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (en_i && hit_term_i && !valid_in) state_d = ST_STALL;
            end
            default: state_d = ST_ARM;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_ARM;
        else         state_q <= state_d;
    end

    // counter commands and divided-output next value
    always_comb begin
        clr_o = 1'b0;
        inc_o = 1'b0;
        load  = 1'b0;
        div_d = div_q;
        unique case (state_q)
            ST_ARM, ST_STALL: begin
                div_d = 1'b0;
                if (en_i && valid_in) begin
                    inc_o = 1'b1;
                    load  = 1'b1;
                    div_d = (eff_in >= CNT_W'(3));
                end
            end
            ST_RUN: begin
                if (en_i) begin
                    if (hit_term_i) begin
                        clr_o = 1'b1;
                        load  = valid_in;
                        div_d = valid_in;
                    end else begin
                        inc_o = 1'b1;
                        if (hit_half_i) div_d = 1'b0;
                    end
                end
            end
            default: div_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ratio_q <= '0;
            div_q   <= 1'b0;
        end else begin
            if (load) ratio_q <= eff_in;
            div_q <= div_d;
        end
    end

    assign ratio_q_o = ratio_q;
    assign running_o = (state_q == ST_RUN);
    assign div_o     = div_q;

    // R2: a disabled edge leaves state, ratio and output untouched
    p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> ($stable(state_q) && $stable(ratio_q) && $stable(div_q)));

    // R5: the ratio in use only moves at a wrap
    p_ratio_steady_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN && !(en_i && hit_term_i)) |=> $stable(ratio_q));

    // R4: passing the half point drops the divided output
    p_half_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN && en_i && hit_half_i && !hit_term_i) |=> !div_q);

    // R4: a wrap into a usable ratio raises the divided output
    p_wrap_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN && en_i && hit_term_i && valid_in) |=> div_q);

    // R7: outside ST_RUN the divided output is low
    p_stall_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_RUN) |-> !div_q);

endmodule

// File: rtl/moddiv_core.sv
module moddiv_core
    import moddiv_pkg::*;
#(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned STAGE_W    = 4,
    parameter bit          SMALL_HOLD = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [CNT_W-1:0] ratio_i,
    output logic [CNT_W-1:0] count_o,
    output logic             term_o,
    output logic             div_o
);

    localparam int unsigned NSTG = CNT_W / STAGE_W;

    logic             clr;
    logic             inc;
    logic             running;
    logic             hit_term;
    logic             hit_half;
    logic [CNT_W-1:0] ratio_q;
    logic [CNT_W-1:0] count;
    logic [NSTG:0]    chain;

    assign chain[0] = inc;

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        moddiv_stage #(
            .W (STAGE_W)
        ) stage_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clr_i   (clr),
            .inc_i   (chain[g]),
            .q_o     (count[g*STAGE_W +: STAGE_W]),
            .carry_o (chain[g+1])
        );
    end

    moddiv_cmp #(
        .CNT_W   (CNT_W),
        .STAGE_W (STAGE_W)
    ) cmp_i (
        .count_i    (count),
        .ratio_i    (ratio_q),
        .hit_term_o (hit_term),
        .hit_half_o (hit_half)
    );

    moddiv_ctrl #(
        .CNT_W      (CNT_W),
        .SMALL_HOLD (SMALL_HOLD)
    ) ctrl_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (en_i),
        .ratio_i    (ratio_i),
        .hit_term_i (hit_term),
        .hit_half_i (hit_half),
        .clr_o      (clr),
        .inc_o      (inc),
        .ratio_q_o  (ratio_q),
        .running_o  (running),
        .div_o      (div_o)
    );

    assign count_o = count;
    assign term_o  = running & hit_term;

    // R2: the count holds across a disabled edge
    p_count_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(count));

    // R3: an enabled terminal cycle is followed by zero
    p_wrap_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (term_o && en_i) |=> (count == '0));

    // R3: while running the count stays below the ratio in use
    p_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        running |-> (count < ratio_q));

    // R3: an enabled non-terminal running cycle advances by one
    p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running && en_i && !hit_term) |=> (count == $past(count) + 1'b1));

    // R7: when not running the count sits at zero and no terminal flag shows
    p_idle_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !running |-> (count == '0 && !term_o));

endmodule

// File: tb/moddiv_core_tb_top.sv
`timescale 1ns/1ps
module moddiv_core_tb_top;

    localparam int CW = 8;
    localparam int SW = 4;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          en_i = 1'b0;
    logic [CW-1:0] ratio_i = '0;
    logic [CW-1:0] count_o;
    logic          term_o;
    logic          div_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // reference model state
    bit m_run = 1'b0;
    int m_cnt = 0;
    int m_r   = 0;

    always #2.5 clk_i = ~clk_i;

    moddiv_core #(
        .CNT_W      (CW),
        .STAGE_W    (SW),
        .SMALL_HOLD (1'b1)
    ) dut_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .ratio_i (ratio_i),
        .count_o (count_o),
        .term_o  (term_o),
        .div_o   (div_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int exp_div();
        if (!m_run) return 0;
        return (m_cnt < (m_r + 1) / 2) ? 1 : 0;
    endfunction

    function automatic int exp_term();
        if (!m_run) return 0;
        return (m_cnt == m_r - 1) ? 1 : 0;
    endfunction

    // one clock edge: advance the model from the requirements, then compare
    task automatic step(input string req);
        int r_in;
        @(posedge clk_i);
        r_in = int'(ratio_i);
        if (en_i) begin
            if (!m_run) begin
                if (r_in >= 2) begin
                    m_run = 1'b1;
                    m_r   = r_in;
                    m_cnt = 1;
                end
            end else if (m_cnt == m_r - 1) begin
                m_cnt = 0;
                if (r_in >= 2) m_r = r_in;
                else           m_run = 1'b0;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
        #1;
        chk(req, "count", int'(count_o), m_cnt);
        chk(req, "div",   int'(div_o),   exp_div());
        chk(req, "term",  int'(term_o),  exp_term());
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        #1;
        m_run = 1'b0;
        m_cnt = 0;
        m_r   = 0;
        chk("R1", "count in reset", int'(count_o), 0);
        chk("R1", "div in reset",   int'(div_o),   0);
        chk("R1", "term in reset",  int'(term_o),  0);
    endtask

    initial begin
        int prev;
        int highs;
        int terms;
        int held;

        // R1: reset state from time zero
        #1;
        do_reset();
        #10;
        rst_ni = 1'b1;

        // R6: first enabled edge takes the live ratio and counts to 1
        ratio_i = 8'd5;
        en_i = 1'b1;
        step("R6");
        chk("R6", "first count", int'(count_o), 1);
        chk("R6", "first div",   int'(div_o),   1);
        for (int i = 0; i < 12; i++) step("R3");

        // R3, R4, R8: every ratio 2..255, each written while the previous runs
        prev = 5;
        for (int n = 2; n < 256; n++) begin
            ratio_i = CW'(n);
            for (int i = 0; i < prev; i++) step("R5");
            for (int i = 0; i < n + 1 && m_cnt != 0; i++) step("R8");
            highs = 0;
            terms = 0;
            for (int k = 0; k < n; k++) begin
                highs += int'(div_o);
                terms += int'(term_o);
                step((n > 16) ? "R8" : "R3");
            end
            chk("R4", "high cycles per period", highs, (n + 1) / 2);
            chk("R3", "terminal cycles per period", terms, 1);
            prev = n;
        end

        // R5: a mid-period change waits for the wrap
        ratio_i = 8'd7;
        for (int i = 0; i < 300 && !(m_run && m_r == 7 && m_cnt == 0); i++) step("R5");
        step("R5");
        step("R5");
        ratio_i = 8'd4;
        for (int i = 0; i < 4; i++) step("R5");
        chk("R5", "old ratio still counting", int'(count_o), 6);
        chk("R5", "old terminal seen", int'(term_o), 1);
        step("R5");
        chk("R5", "wrap", int'(count_o), 0);
        for (int i = 0; i < 3; i++) step("R5");
        chk("R5", "new terminal", int'(term_o), 1);

        // R2: gated enable
        ratio_i = 8'd6;
        for (int i = 0; i < 60; i++) begin
            en_i = ((i % 3) != 0) && ((i % 7) != 2);
            step("R2");
        end
        en_i = 1'b0;
        held = int'(count_o);
        for (int i = 0; i < 5; i++) step("R2");
        chk("R2", "held count", int'(count_o), held);
        en_i = 1'b1;

        // R7: ratios 0 and 1 stall at the next wrap
        ratio_i = 8'd0;
        for (int i = 0; i < 10; i++) step("R7");
        chk("R7", "stalled count", int'(count_o), 0);
        chk("R7", "stalled div",   int'(div_o),   0);
        ratio_i = 8'd1;
        for (int i = 0; i < 5; i++) step("R7");
        chk("R7", "stalled term",  int'(term_o),  0);
        ratio_i = 8'd2;
        step("R6");
        chk("R6", "leave stall count", int'(count_o), 1);
        chk("R6", "ratio 2 div low",   int'(div_o),   0);
        for (int i = 0; i < 8; i++) step("R4");

        // R1: reset between edges in mid-run
        ratio_i = 8'd9;
        for (int i = 0; i < 13; i++) step("R3");
        @(negedge clk_i);
        #0.7;
        do_reset();
        #6;
        rst_ni = 1'b1;
        ratio_i = 8'd3;
        step("R6");
        for (int i = 0; i < 9; i++) step("R4");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #950000;
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule